// File: doc/BRIEF.md
# Conveyor Rod Length Sorter

This block sorts rods on a conveyor by length. Three light beams cross the belt, and each beam reads 1 while a rod blocks it. A rod meets beam C first, then beam B, then beam A. Beam B sits at the nominal length minus 5% ahead of A, and beam C sits at the nominal length plus 5% ahead of A. Every rod lies within ±10% of nominal.

At the moment a rod first blocks beam A, the block reads the other two beams. If neither is blocked, the rod is short and stays on the belt. If only B is blocked, the rod is in spec and one arm pushes it off to one side. If both are blocked, the rod is too long and the other arm pushes it off to the opposite side. Rods are spaced at least one maximum rod length apart, so the pattern A and C blocked with B clear cannot occur. If that pattern is seen anyway, the block raises a sticky error flag and moves no arm.

The raw beam signals are asynchronous, so each passes through a synchroniser. The block drives each arm with a fixed-length pulse. It also gives one-cycle strobes, one for each decision class, so that the surrounding logic can count results.

Top module: `rod_sorter`

## Requirements
- R1: Each beam input passes through a two-flop synchroniser, followed by one register stage. The decision strobe goes high 3 clock cycles after the cycle in which raw beam_a is first seen at 1.
- R2: While synchronised beam_a is 0, any pattern on beam_b and beam_c produces no strobe, no arm pulse and no error.
- R3: On a rise of beam_a with beam_b=0 and beam_c=0 (short rod), strobe_short pulses and neither arm moves.
- R4: On a rise of beam_a with beam_b=1 and beam_c=0 (in-spec rod), strobe_good pulses and arm_good gives a pulse.
- R5: On a rise of beam_a with beam_b=1 and beam_c=1 (over-length rod), strobe_long pulses and arm_long gives a pulse.
- R6: An arm pulse starts in the cycle after its strobe and stays high for exactly PULSE_CYCLES cycles.
- R7: While beam_a stays at 1, changes on beam_b or beam_c cause no further decision. A new decision needs beam_a to return to 0 first.
- R8: On a rise of beam_a with beam_b=0 and beam_c=1, err_flag goes high and stays high until err_clear is asserted. This decision gives no strobe and no arm pulse. If a new error and err_clear arrive in the same cycle, the error wins.
- R9: A synchronous active-high rst clears the synchronisers, the strobes, both arms, the pulse counters and err_flag.
- R10: Each strobe lasts one cycle, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beam_a | input | 1 | Raw beam A, the decision beam (1 = blocked) |
| beam_b | input | 1 | Raw beam B, placed at nominal minus 5% from A |
| beam_c | input | 1 | Raw beam C, placed at nominal plus 5% from A |
| err_clear | input | 1 | Clears the sticky error flag |
| arm_long | output | 1 | Pulse that drives the over-length arm |
| arm_good | output | 1 | Pulse that drives the in-spec arm |
| strobe_short | output | 1 | One-cycle strobe for a short-rod decision |
| strobe_good | output | 1 | One-cycle strobe for an in-spec decision |
| strobe_long | output | 1 | One-cycle strobe for an over-length decision |
| err_flag | output | 1 | Sticky flag for the impossible pattern |

## Verification
Rods are fed with each of the four patterns that can appear at the decision instant: 100, 110, 111 and 101. Together these tell apart the short, in-spec, long and error outcomes, and they show which arm moves and for how many cycles. Transit patterns with A clear confirm that beams B and C alone never trigger a decision. A test that holds A high and changes B and C shows that one rod gives only one decision. Directed cases cover an error raised while err_clear is held and a reset in the middle of a pulse. A seeded random stream mixes all of these patterns.

// File: rtl/rod_sorter_pkg.sv
package rod_sorter_pkg;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_SHORT,
    CLS_GOOD,
    CLS_LONG,
    CLS_BAD
  } rod_class_e;

  // Spatial pattern of the three beams -> length class
  function automatic rod_class_e classify(input logic a, input logic b, input logic c);
    rod_class_e r;
    if (!a) begin
      r = CLS_NONE;
    end else begin
      case ({b, c})
        2'b00:   r = CLS_SHORT;
        2'b10:   r = CLS_GOOD;
        2'b11:   r = CLS_LONG;
        default: r = CLS_BAD;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/beam_sync.sv
module beam_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rod_decider.sv
module rod_decider
  import rod_sorter_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_s,
  input  logic b_s,
  input  logic c_s,
  input  logic err_clear,
  output logic strobe_short,
  output logic strobe_good,
  output logic strobe_long,
  output logic err_flag
);
  logic       a_prev;
  logic       a_rise;
  rod_class_e cls;

  assign a_rise = a_s & ~a_prev;
  assign cls    = classify(a_s, b_s, c_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev       <= 1'b0;
      strobe_short <= 1'b0;
      strobe_good  <= 1'b0;
      strobe_long  <= 1'b0;
      err_flag     <= 1'b0;
    end else begin
      a_prev       <= a_s;
      strobe_short <= a_rise && (cls == CLS_SHORT);
      strobe_good  <= a_rise && (cls == CLS_GOOD);
      strobe_long  <= a_rise && (cls == CLS_LONG);
      if (a_rise && (cls == CLS_BAD)) err_flag <= 1'b1;
      else if (err_clear)             err_flag <= 1'b0;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe_short, strobe_good, strobe_long})); // R10
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (strobe_short || strobe_good || strobe_long) |=> !(strobe_short || strobe_good || strobe_long)); // R10
  AST_HELD_NO_DECIDE: assert property (@(posedge clk) disable iff (rst)
    (a_s && a_prev) |=> !(strobe_short || strobe_good || strobe_long)); // R7
  AST_IDLE_NO_DECIDE: assert property (@(posedge clk) disable iff (rst)
    !a_s |=> !(strobe_short || strobe_good || strobe_long)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clear) |=> err_flag); // R8
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    (a_rise && !b_s && c_s) |=> (err_flag && !(strobe_short || strobe_good || strobe_long))); // R8
endmodule

// File: rtl/arm_pulser.sv
module arm_pulser #(
  parameter int PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic arm_o
);
  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] remain_q;
  logic             last_cycle;

  assign last_cycle = (remain_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_o    <= 1'b0;
      remain_q <= '0;
    end else if (fire) begin
      arm_o    <= 1'b1;
      remain_q <= LOAD;
    end else if (arm_o) begin
      if (last_cycle) arm_o <= 1'b0;
      else            remain_q <= remain_q - 1'b1;
    end
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
    fire |=> arm_o); // R6
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (arm_o && !last_cycle) |=> arm_o); // R6
  AST_PULSE_END: assert property (@(posedge clk) disable iff (rst)
    (arm_o && last_cycle && !fire) |=> !arm_o); // R6
endmodule

// File: rtl/rod_sorter.sv
module rod_sorter #(
  parameter int PULSE_CYCLES = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic beam_a,
  input  logic beam_b,
  input  logic beam_c,
  input  logic err_clear,
  output logic arm_long,
  output logic arm_good,
  output logic strobe_short,
  output logic strobe_good,
  output logic strobe_long,
  output logic err_flag
);
  localparam int NUM_BEAMS = 3;

  logic [NUM_BEAMS-1:0] beams_sync;

  beam_sync #(.WIDTH(NUM_BEAMS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({beam_a, beam_b, beam_c}),
    .q   (beams_sync)
  );

  rod_decider u_decide (
    .clk          (clk),
    .rst          (rst),
    .a_s          (beams_sync[2]),
    .b_s          (beams_sync[1]),
    .c_s          (beams_sync[0]),
    .err_clear    (err_clear),
    .strobe_short (strobe_short),
    .strobe_good  (strobe_good),
    .strobe_long  (strobe_long),
    .err_flag     (err_flag)
  );

  arm_pulser #(.PULSE_CYCLES(PULSE_CYCLES)) u_arm_long (
    .clk   (clk),
    .rst   (rst),
    .fire  (strobe_long),
    .arm_o (arm_long)
  );

  arm_pulser #(.PULSE_CYCLES(PULSE_CYCLES)) u_arm_good (
    .clk   (clk),
    .rst   (rst),
    .fire  (strobe_good),
    .arm_o (arm_good)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> !(arm_long || arm_good || strobe_short || strobe_good || strobe_long || err_flag)); // R9
endmodule

// File: tb/rod_sorter_bench.sv
module rod_sorter_bench;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic beam_a = 1'b0, beam_b = 1'b0, beam_c = 1'b0, err_clear = 1'b0;
  logic arm_long, arm_good, strobe_short, strobe_good, strobe_long, err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rod_sorter #(.PULSE_CYCLES(P), .SYNC_STAGES(2)) u_rod_sorter (
    .clk(clk), .rst(rst), .beam_a(beam_a), .beam_b(beam_b), .beam_c(beam_c),
    .err_clear(err_clear), .arm_long(arm_long), .arm_good(arm_good),
    .strobe_short(strobe_short), .strobe_good(strobe_good),
    .strobe_long(strobe_long), .err_flag(err_flag)
  );

  // Expected class: 0 none, 1 short, 2 good, 3 long, 4 impossible
  function automatic int expect_class(input logic [2:0] abc);
    if (abc == 3'b100) return 1;
    if (abc == 3'b110) return 2;
    if (abc == 3'b111) return 3;
    if (abc == 3'b101) return 4;
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_all();
    beam_a = 0; beam_b = 0; beam_c = 0;
    cyc(6);
  endtask

  // One rod reaching beam A with pattern abc; observes P+6 cycles
  task automatic run_rod(input logic [2:0] abc, input bit hold_clear);
    int cls, n_s, n_g, n_l, at_s, at_g, at_l, ag, al, ag_first, al_first, err3;
    cls = expect_class(abc);
    n_s = 0; n_g = 0; n_l = 0; at_s = 0; at_g = 0; at_l = 0;
    ag = 0; al = 0; ag_first = 0; al_first = 0; err3 = 0;
    beam_c = abc[0]; cyc(2);
    beam_b = abc[1]; cyc(2);
    err_clear = hold_clear;
    beam_a = 1'b1;
    for (int i = 1; i <= P + 6; i++) begin
      @(negedge clk);
      if (strobe_short) begin n_s++; at_s = i; end
      if (strobe_good)  begin n_g++; at_g = i; end
      if (strobe_long)  begin n_l++; at_l = i; end
      if (arm_good) begin ag++; if (ag_first == 0) ag_first = i; end
      if (arm_long) begin al++; if (al_first == 0) al_first = i; end
      if (i == 3) err3 = err_flag;
    end
    chk("R3 short strobe count", n_s, (cls == 1) ? 1 : 0);
    chk("R4 good strobe count", n_g, (cls == 2) ? 1 : 0);
    chk("R5 long strobe count", n_l, (cls == 3) ? 1 : 0);
    chk("R6 arm_good high cycles", ag, (cls == 2) ? P : 0);
    chk("R6 arm_long high cycles", al, (cls == 3) ? P : 0);
    if (cls == 1) chk("R1 short strobe latency", at_s, 3);
    if (cls == 2) begin
      chk("R1 good strobe latency", at_g, 3);
      chk("R6 arm_good start", ag_first, 4);
    end
    if (cls == 3) begin
      chk("R1 long strobe latency", at_l, 3);
      chk("R6 arm_long start", al_first, 4);
    end
    if (cls == 4) begin
      chk("R8 error set on 101", err3, 1);
      chk("R8 error sticky or cleared", err_flag, hold_clear ? 0 : 1);
      err_clear = 1'b1; cyc(1); err_clear = 1'b0; cyc(1);
      chk("R8 error cleared", err_flag, 0);
    end else begin
      chk("R8 no error", err_flag, 0);
    end
    err_clear = 1'b0;
    idle_all();
  endtask

  // Beams B/C move while A is clear: nothing may happen
  task automatic run_transit(input logic [1:0] bc);
    int seen;
    seen = 0;
    beam_a = 0; beam_b = bc[1]; beam_c = bc[0];
    for (int i = 0; i < P + 4; i++) begin
      @(negedge clk);
      seen += int'(strobe_short) + int'(strobe_good) + int'(strobe_long)
            + int'(arm_good) + int'(arm_long) + int'(err_flag);
    end
    chk("R2 transit produces nothing", seen, 0);
    idle_all();
  endtask

  initial begin
    int seen;
    int r;
    cyc(3);
    chk("R9 reset arms", int'(arm_long) + int'(arm_good), 0);
    chk("R9 reset strobes/err", int'(strobe_short) + int'(strobe_good) + int'(strobe_long) + int'(err_flag), 0);
    rst = 0;
    cyc(4);

    // Directed corner cases
    run_rod(3'b100, 0);
    run_rod(3'b110, 0);
    run_rod(3'b111, 0);
    run_rod(3'b101, 0);
    run_rod(3'b101, 1);   // R8: set wins over simultaneous clear
    run_transit(2'b11);
    run_transit(2'b10);

    // R7: A held high, B/C change, no second decision
    beam_c = 0; beam_b = 0; beam_a = 1; cyc(6);
    seen = 0;
    beam_b = 1; beam_c = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      seen += int'(strobe_short) + int'(strobe_good) + int'(strobe_long) + int'(arm_long);
    end
    chk("R7 no decision while A held", seen, 0);
    idle_all();

    // R9: reset in the middle of a pulse
    beam_b = 1; beam_a = 1; cyc(6);
    chk("R9 pulse running before reset", arm_good, 1);
    rst = 1; beam_a = 0; beam_b = 0; cyc(1);
    chk("R9 reset clears arm", arm_good, 0);
    cyc(3); rst = 0; cyc(4);
    chk("R9 nothing after reset release", int'(arm_good) + int'(strobe_good), 0);

    // R10 / random stream
    r = $urandom(32'hC0FFEE);
    for (int k = 0; k < 40; k++) begin
      r = $urandom % 5;
      case (r)
        0: run_transit(2'($urandom % 4));
        1: run_rod(3'b100, 0);
        2: run_rod(3'b110, 0);
        3: run_rod(3'b111, 0);
        default: run_rod(3'b101, 1'($urandom % 2));
      endcase
    end
    done = 1;
  end

  // R10: strobes exclusive and single-cycle, watched all run
  logic prev_any = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (int'(strobe_short) + int'(strobe_good) + int'(strobe_long) > 1) begin
        errors++; $display("FAIL R10 multiple strobes actual>1 expected<=1");
      end
      if (prev_any && (strobe_short || strobe_good || strobe_long)) begin
        errors++; $display("FAIL R10 strobe longer than one cycle actual=2 expected=1");
      end
    end
    prev_any <= strobe_short || strobe_good || strobe_long;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule